// File: doc/BRIEF.md
# Serial Line Receiver With Modem Status

This block is the receive side of an asynchronous serial line interface. A free-running divider produces a sample tick at sixteen times the bit rate. The deframer uses these ticks to find a start bit, confirm it at mid-bit, and collect 5 to 8 data bits, least significant bit first. An optional odd or even parity bit follows, and the block then samples the first stop bit. The finished character and its error flags are held in a buffer register until the next character completes, so software has a full character time to collect it.

Software reaches the block through a simple select/strobe register bus with two 16-bit words. The status word holds the following:
- the synchronized modem lines (carrier, ring, secondary receive);
- a receiver-active flag;
- the done flag and the two interrupt enables;
- a terminal-ready bit;
- a write-only reader-run request;
- a read-once dataset-change flag.

Two interrupt requests leave the block. The data request takes precedence over the dataset request. A maintenance loopback input lets the transmitter output replace the line input.

Top module: `slrx_line_receiver`

## Requirements
- R1: A frame is a low start bit, then N = 5 + cfg_len data bits sent LSB first. The character reads right-justified in buffer bits 7:0, and buffer bits above N-1 within 7:0 read 0.
- R2: Status bit 15 (dataset change) sets when any of these change: carrier (status bit 12), receiver active (bit 11) or secondary receive (bit 10). It also sets when ring (bit 14) rises from 0 to 1. A fall of ring does not set it. The bit clears when the status word is read or on INIT, and a new change in the same cycle as a read wins.
- R3: Status bit 11 (receiver active) sets at the confirmed centre of the start bit. It clears in the cycle that done sets.
- R4: Status bit 7 (done) sets at the middle of the first stop bit. It clears on any read or write of the buffer word, on a status write with bit 0 = 1, or on INIT.
- R5: Status bits 6 (data interrupt enable) and 5 (dataset interrupt enable) are read/write and cleared by INIT. Bit 1 (terminal ready, driven on dtr_out) is read/write and survives INIT. Bit 0 always reads 0. Writing bit 0 = 1 raises reader_run, which clears at the next confirmed start-bit centre or on INIT.
- R6: Buffer bit 14 flags overrun (a character completed while done was set), bit 13 flags framing (stop bit sampled low) and bit 12 flags parity, with bit 15 their OR. cfg_par_odd = 1 selects odd parity and 0 selects even. Bit 12 is 0 whenever cfg_par_en = 0.
- R7: The character and the error bits change only when a later character completes. Reads and INIT leave them unchanged.
- R8: data_irq = done AND status bit 6. dset_irq = dataset flag AND status bit 5, asserted only while data_irq is low.
- R9: Each bit is 16 sample ticks. A start bit that is low at its first sample but high at its centre is discarded: receiver active, done and the dataset flag all stay unchanged.
- R10: While loop_en = 1 the receiver takes its line from loop_tx and ignores rx_serial.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Bus INIT, synchronous |
| rx_serial | input | 1 | Serial line input, idle high |
| loop_en | input | 1 | Select maintenance loopback |
| loop_tx | input | 1 | Transmitter output for loopback |
| carrier | input | 1 | Carrier detect modem line |
| ring | input | 1 | Ring indicator modem line |
| sec_rx | input | 1 | Secondary receive modem line |
| cfg_len | input | 2 | Data bits minus 5 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| sel_status | input | 1 | Status word addressed |
| sel_buffer | input | 1 | Buffer word addressed |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid while rd is high |
| data_irq | output | 1 | Character interrupt request |
| dset_irq | output | 1 | Dataset interrupt request |
| dtr_out | output | 1 | Terminal-ready bit |
| reader_run | output | 1 | Reader-run request |

## Verification
Some behaviours are checked by assertions on every clock edge:
- done can only rise after a completed frame;
- receiver active falls with each completed frame, and a rejected start leaves it low;
- a modem or activity change always leaves the dataset flag set;
- reader_run drops at a confirmed start;
- the held character changes only on frame completion;
- sample ticks are never back to back.

Other behaviours can only be shown by the bench scenarios, because they depend on bit patterns and register traffic rather than single-cycle relations:
- the value of an assembled character for each length;
- parity in both senses;
- framing and overrun flags, and that they persist across reads and INIT;
- the one-way sensitivity to ring;
- interrupt precedence;
- loopback isolation.

// File: rtl/slrx_pkg.sv
package slrx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

  // Index of the last data bit for a length code (length = 5 + code).
  function automatic logic [2:0] last_bit_idx(input logic [1:0] code);
    return 3'd4 + {1'b0, code};
  endfunction

  // Bits arrive LSB first into the top of the shifter; move them down.
  function automatic logic [7:0] align_char(input logic [7:0] sh,
                                            input logic [1:0] code);
    return sh >> (2'd3 - code);
  endfunction

  // True when the received parity bit disagrees with the chosen sense.
  function automatic logic parity_bad(input logic [7:0] ch,
                                      input logic pbit,
                                      input logic odd);
    logic ones;
    ones = (^ch) ^ pbit;
    return odd ? ~ones : ones;
  endfunction

endpackage

// File: rtl/slrx_bit_timer.sv
module slrx_bit_timer #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);

  // R9: sample ticks are spaced by the divider, never adjacent
  a_r9_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/slrx_deframer.sv
module slrx_deframer
  import slrx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init,
  input  logic       tick,
  input  logic       line_in,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  output logic       rx_active,
  output logic       mid_start,
  output logic       frame_done,
  output logic [7:0] char_out,
  output logic       stop_bad,
  output logic       par_bad
);
  localparam int PW = $clog2(OVS);
  localparam logic [PW-1:0] PH_MID  = PW'(OVS / 2 - 1);
  localparam logic [PW-1:0] PH_LAST = PW'(OVS - 1);

  rx_state_e     state;
  logic [PW-1:0] ph;
  logic [2:0]    nbit;
  logic [7:0]    sh;
  logic          pbit;
  logic          line_m, line_s;
  logic          noise_reject;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_m <= 1'b1;
      line_s <= 1'b1;
    end else begin
      line_m <= line_in;
      line_s <= line_m;
    end
  end

  assign mid_start    = !init && tick && state == RX_START && ph == PH_MID && !line_s;
  assign noise_reject = !init && tick && state == RX_START && ph == PH_MID && line_s;
  assign frame_done   = !init && tick && state == RX_STOP && ph == PH_LAST;
  assign char_out     = align_char(sh, cfg_len);
  assign stop_bad     = !line_s;
  assign par_bad      = cfg_par_en && parity_bad(char_out, pbit, cfg_par_odd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RX_IDLE;
      ph    <= '0;
      nbit  <= '0;
      sh    <= '0;
      pbit  <= 1'b0;
    end else if (init) begin
      state <= RX_IDLE;
      ph    <= '0;
    end else if (tick) begin
      unique case (state)
        RX_IDLE: begin
          if (!line_s) begin
            state <= RX_START;
            ph    <= '0;
          end
        end
        RX_START: begin
          if (ph == PH_MID) begin
            ph   <= '0;
            nbit <= '0;
            state <= line_s ? RX_IDLE : RX_DATA;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        RX_DATA: begin
          if (ph == PH_LAST) begin
            ph <= '0;
            sh <= {line_s, sh[7:1]};
            if (nbit == last_bit_idx(cfg_len))
              state <= cfg_par_en ? RX_PAR : RX_STOP;
            else
              nbit <= nbit + 1'b1;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        RX_PAR: begin
          if (ph == PH_LAST) begin
            ph    <= '0;
            pbit  <= line_s;
            state <= RX_STOP;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        RX_STOP: begin
          if (ph == PH_LAST) begin
            ph    <= '0;
            state <= RX_IDLE;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rx_active <= 1'b0;
    else if (init)       rx_active <= 1'b0;
    else if (mid_start)  rx_active <= 1'b1;
    else if (frame_done) rx_active <= 1'b0;
  end

  // R3: receiver active drops with each completed frame
  a_r3_active_drops: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !rx_active);

  // R9: a start bit high at its centre is thrown away
  a_r9_noise_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (noise_reject && !rx_active) |=> (!rx_active && state == RX_IDLE));

endmodule

// File: rtl/slrx_modem_watch.sv
module slrx_modem_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic carrier,
  input  logic ring,
  input  logic sec_rx,
  input  logic rx_active,
  output logic carrier_s,
  output logic ring_s,
  output logic sec_s,
  output logic change
);
  logic [2:0] meta, sync, prev;
  logic       act_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta     <= '0;
      sync     <= '0;
      prev     <= '0;
      act_prev <= 1'b0;
    end else begin
      meta     <= {carrier, ring, sec_rx};
      sync     <= meta;
      prev     <= sync;
      act_prev <= rx_active;
    end
  end

  assign carrier_s = sync[2];
  assign ring_s    = sync[1];
  assign sec_s     = sync[0];

  // Ring counts only on its rising edge; the others on any change.
  assign change = (sync[2] ^ prev[2]) | (sync[1] & ~prev[1]) |
                  (sync[0] ^ prev[0]) | (rx_active ^ act_prev);

endmodule

// File: rtl/slrx_line_receiver.sv
module slrx_line_receiver
  import slrx_pkg::*;
#(
  parameter int DIV = 4,
  parameter int OVS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        rx_serial,
  input  logic        loop_en,
  input  logic        loop_tx,
  input  logic        carrier,
  input  logic        ring,
  input  logic        sec_rx,
  input  logic [1:0]  cfg_len,
  input  logic        cfg_par_en,
  input  logic        cfg_par_odd,
  input  logic        sel_status,
  input  logic        sel_buffer,
  input  logic        rd,
  input  logic        wr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        data_irq,
  output logic        dset_irq,
  output logic        dtr_out,
  output logic        reader_run
);
  logic       tick, rx_active, mid_start, frame_done, stop_bad, par_bad;
  logic [7:0] char_out;
  logic       carrier_s, ring_s, sec_s, ds_change;

  logic       dset_flag, done_q, ie_data, ie_dset, dtr, reader_en;
  logic [7:0] char_q;
  logic       ovr_q, frm_q, par_q;

  logic       wr_status, rd_status, buf_touch, re_write;
  logic       unused_wdata;

  slrx_bit_timer #(.DIV(DIV)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  slrx_deframer #(.OVS(OVS)) u_deframer (
    .clk(clk), .rst_n(rst_n), .init(init), .tick(tick),
    .line_in(loop_en ? loop_tx : rx_serial),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .rx_active(rx_active), .mid_start(mid_start), .frame_done(frame_done),
    .char_out(char_out), .stop_bad(stop_bad), .par_bad(par_bad)
  );

  slrx_modem_watch u_modem (
    .clk(clk), .rst_n(rst_n), .carrier(carrier), .ring(ring),
    .sec_rx(sec_rx), .rx_active(rx_active), .carrier_s(carrier_s),
    .ring_s(ring_s), .sec_s(sec_s), .change(ds_change)
  );

  assign wr_status = sel_status && wr;
  assign rd_status = sel_status && rd;
  assign buf_touch = sel_buffer && (rd || wr);
  assign re_write  = wr_status && wdata[0];
  assign unused_wdata = &{1'b0, wdata[15:7], wdata[4:2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dset_flag <= 1'b0;
      done_q    <= 1'b0;
      ie_data   <= 1'b0;
      ie_dset   <= 1'b0;
      reader_en <= 1'b0;
    end else if (init) begin
      dset_flag <= 1'b0;
      done_q    <= 1'b0;
      ie_data   <= 1'b0;
      ie_dset   <= 1'b0;
      reader_en <= 1'b0;
    end else begin
      if (ds_change)      dset_flag <= 1'b1;
      else if (rd_status) dset_flag <= 1'b0;

      if (frame_done)                 done_q <= 1'b1;
      else if (buf_touch || re_write) done_q <= 1'b0;

      if (wr_status) begin
        ie_data <= wdata[6];
        ie_dset <= wdata[5];
      end

      if (re_write)       reader_en <= 1'b1;
      else if (mid_start) reader_en <= 1'b0;
    end
  end

  // Terminal ready is kept across INIT; only reset clears it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dtr <= 1'b0;
    else if (wr_status) dtr <= wdata[1];
  end

  // Held character and error flags: loaded only by a completed frame.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      char_q <= '0;
      ovr_q  <= 1'b0;
      frm_q  <= 1'b0;
      par_q  <= 1'b0;
    end else if (frame_done) begin
      char_q <= char_out;
      ovr_q  <= done_q;
      frm_q  <= stop_bad;
      par_q  <= par_bad;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd && sel_status)
      rdata = {dset_flag, ring_s, 1'b0, carrier_s, rx_active, sec_s, 2'b00,
               done_q, ie_data, ie_dset, 3'b000, dtr, 1'b0};
    else if (rd && sel_buffer)
      rdata = {ovr_q | frm_q | par_q, ovr_q, frm_q, par_q, 4'b0000, char_q};
  end

  assign data_irq   = done_q && ie_data;
  assign dset_irq   = dset_flag && ie_dset && !data_irq;
  assign dtr_out    = dtr;
  assign reader_run = reader_en;

  // R4: done only rises on the cycle after a completed frame
  a_r4_done_from_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(frame_done));

  // R2: a detected modem or activity change leaves the flag set
  a_r2_change_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_change && !init) |=> dset_flag);

  // R5: reader request drops at a confirmed start centre
  a_r5_reader_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_start && !re_write) |=> !reader_en);

  // R7: held character moves only with a completed frame
  a_r7_char_held: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(char_q));

endmodule

// File: tb/slrx_line_receiver_test.sv
module slrx_line_receiver_test;
  localparam int BIT = 64;  // 16 ticks x 4 clocks

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init = 1'b0;
  logic        rx_serial = 1'b1;
  logic        loop_en = 1'b0;
  logic        loop_tx = 1'b1;
  logic        carrier = 1'b0, ring = 1'b0, sec_rx = 1'b0;
  logic [1:0]  cfg_len = 2'd3;
  logic        cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic        sel_status = 1'b0, sel_buffer = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        data_irq, dset_irq, dtr_out, reader_run;

  int checks = 0;
  int errors = 0;
  bit exp_ie_data = 1'b0, exp_ie_dset = 1'b0, running = 1'b0;

  always #5 clk = ~clk;

  slrx_line_receiver uut (
    .clk(clk), .rst_n(rst_n), .init(init), .rx_serial(rx_serial),
    .loop_en(loop_en), .loop_tx(loop_tx), .carrier(carrier), .ring(ring),
    .sec_rx(sec_rx), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .sel_status(sel_status),
    .sel_buffer(sel_buffer), .rd(rd), .wr(wr), .wdata(wdata),
    .rdata(rdata), .data_irq(data_irq), .dset_irq(dset_irq),
    .dtr_out(dtr_out), .reader_run(reader_run)
  );

  task automatic check(input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Per-clock model of the interrupt outputs (R8).
  always @(negedge clk) begin
    if (running) begin
      checks++;
      if ((data_irq && !exp_ie_data) ||
          (dset_irq && (data_irq || !exp_ie_dset))) begin
        errors++;
        $display("FAIL R8 per-clock: actual data=%0b dset=%0b expected ie=%0b/%0b exclusive",
                 data_irq, dset_irq, exp_ie_data, exp_ie_dset);
      end
    end
  end

  task automatic bus_read(input bit status, output logic [15:0] v);
    @(negedge clk);
    sel_status = status; sel_buffer = !status; rd = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    sel_status = 1'b0; sel_buffer = 1'b0; rd = 1'b0;
  endtask

  task automatic bus_write(input logic [15:0] v);
    @(negedge clk);
    sel_status = 1'b1; wr = 1'b1; wdata = v;
    @(posedge clk);
    #1 exp_ie_data = v[6]; exp_ie_dset = v[5];
    @(negedge clk);
    sel_status = 1'b0; wr = 1'b0; wdata = '0;
  endtask

  task automatic pulse_init();
    @(negedge clk);
    init = 1'b1;
    @(posedge clk);
    #1 exp_ie_data = 1'b0; exp_ie_dset = 1'b0;
    @(negedge clk);
    init = 1'b0;
  endtask

  task automatic drive(input bit via_loop, input logic b, input int n);
    if (via_loop) loop_tx = b; else rx_serial = b;
    repeat (n) @(negedge clk);
  endtask

  // stop_low > 0 holds the stop bit low for that many clocks (framing error).
  task automatic send(input logic [7:0] d, input int n, input bit haspar,
                      input logic pb, input int stop_low, input bit via_loop);
    @(negedge clk);
    drive(via_loop, 1'b0, BIT);
    for (int i = 0; i < n; i++) drive(via_loop, d[i], BIT);
    if (haspar) drive(via_loop, pb, BIT);
    if (stop_low > 0) begin
      drive(via_loop, 1'b0, stop_low);
      drive(via_loop, 1'b1, BIT - stop_low);
    end else begin
      drive(via_loop, 1'b1, BIT);
    end
    drive(via_loop, 1'b1, BIT);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    running = 1'b1;
    repeat (4) @(negedge clk);

    // Reset state
    bus_read(1'b1, v); check("R5 reset status", v, 16'h0000);
    bus_read(1'b0, v); check("R1 reset buffer", v, 16'h0000);

    // R5: enables and terminal ready are read/write
    bus_write(16'h0042);
    bus_read(1'b1, v); check("R5 status readback", v, 16'h0042);
    check("R5 dtr_out", {15'd0, dtr_out}, 16'h0001);

    // R1/R4/R8: 8-bit character, no parity
    send(8'hA5, 8, 1'b0, 1'b0, 0, 1'b0);
    check("R8 data_irq on done", {15'd0, data_irq}, 16'h0001);
    bus_read(1'b1, v); check("R2 R4 status after frame", v, 16'h80C2);
    bus_read(1'b0, v); check("R1 char 8 bits", v, 16'h00A5);
    bus_read(1'b1, v); check("R4 done cleared by buffer read", v, 16'h0042);
    check("R8 data_irq off", {15'd0, data_irq}, 16'h0000);

    // R1/R6: 5-bit character, even parity, correct parity bit
    cfg_len = 2'd0; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
    send(8'h13, 5, 1'b1, ^(5'h13), 0, 1'b0);
    bus_read(1'b0, v); check("R1 R6 5-bit even parity good", v, 16'h0013);

    // R6: odd parity with an even-sense bit -> parity error
    cfg_par_odd = 1'b1;
    send(8'h13, 5, 1'b1, ^(5'h13), 0, 1'b0);
    bus_read(1'b0, v); check("R6 parity error", v, 16'h9013);
    bus_read(1'b0, v); check("R7 flags persist after read", v, 16'h9013);
    pulse_init();
    bus_read(1'b0, v); check("R7 INIT keeps buffer", v, 16'h9013);
    bus_read(1'b1, v); check("R5 INIT clears enables keeps dtr", v, 16'h0002);

    // R6: framing error, 8 bits, no parity (stop held low 48 clocks)
    cfg_len = 2'd3; cfg_par_en = 1'b0;
    send(8'h3C, 8, 1'b0, 1'b0, 48, 1'b0);
    bus_read(1'b0, v); check("R6 framing error", v, 16'hA03C);

    // R6/R7: overrun, then cleared by the next character
    send(8'h11, 8, 1'b0, 1'b0, 0, 1'b0);
    send(8'h22, 8, 1'b0, 1'b0, 0, 1'b0);
    bus_read(1'b0, v); check("R6 overrun", v, 16'hC022);
    send(8'h33, 8, 1'b0, 1'b0, 0, 1'b0);
    bus_read(1'b0, v); check("R7 flags replaced by next char", v, 16'h0033);

    // R9: short low glitch is discarded
    bus_read(1'b1, v);
    @(negedge clk);
    drive(1'b0, 1'b0, 20);
    drive(1'b0, 1'b1, 200);
    bus_read(1'b1, v); check("R9 glitch leaves status idle", v, 16'h0002);
    bus_read(1'b0, v); check("R9 glitch leaves buffer", v, 16'h0033);

    // R3: receiver active mid-frame, cleared once done
    fork
      send(8'h5C, 8, 1'b0, 1'b0, 0, 1'b0);
      begin
        repeat (3 * BIT) @(negedge clk);
        bus_read(1'b1, v); check("R3 active mid-frame", v & 16'h0880, 16'h0800);
      end
    join
    bus_read(1'b1, v); check("R3 active clear done set", v & 16'h0880, 16'h0080);

    // R4/R5: reader enable write clears done, sets reader_run
    bus_write(16'h0003);
    bus_read(1'b1, v); check("R4 R5 RE write clears done bit0 reads 0", v, 16'h0002);
    check("R5 reader_run set", {15'd0, reader_run}, 16'h0001);
    send(8'h01, 8, 1'b0, 1'b0, 0, 1'b0);
    check("R5 reader_run cleared by start", {15'd0, reader_run}, 16'h0000);
    bus_read(1'b0, v); check("R1 char after RE", v, 16'h0001);

    // R2/R8: dataset changes
    bus_write(16'h0022);
    bus_read(1'b1, v);
    carrier = 1'b1; repeat (10) @(negedge clk);
    check("R8 dset_irq on carrier", {15'd0, dset_irq}, 16'h0001);
    bus_read(1'b1, v); check("R2 carrier change", v, 16'h9022);
    check("R2 read clears flag", {15'd0, dset_irq}, 16'h0000);
    ring = 1'b1; repeat (10) @(negedge clk);
    bus_read(1'b1, v); check("R2 ring rise", v, 16'hD022);
    ring = 1'b0; repeat (10) @(negedge clk);
    check("R2 ring fall ignored irq", {15'd0, dset_irq}, 16'h0000);
    bus_read(1'b1, v); check("R2 ring fall ignored", v, 16'h1022);
    sec_rx = 1'b1; repeat (10) @(negedge clk);
    bus_read(1'b1, v); check("R2 secondary change", v, 16'h9422);
    carrier = 1'b0; sec_rx = 1'b0; repeat (10) @(negedge clk);
    bus_read(1'b1, v);

    // R8: data interrupt takes precedence
    bus_write(16'h0062);
    carrier = 1'b1; repeat (10) @(negedge clk);
    check("R8 dset alone", {14'd0, data_irq, dset_irq}, 16'h0001);
    send(8'h77, 8, 1'b0, 1'b0, 0, 1'b0);
    check("R8 data wins", {14'd0, data_irq, dset_irq}, 16'h0002);
    bus_read(1'b0, v); check("R1 char 0x77", v, 16'h0077);
    check("R8 dset after data served", {14'd0, data_irq, dset_irq}, 16'h0001);

    // R10: loopback ignores the line input
    loop_en = 1'b1;
    @(negedge clk);
    rx_serial = 1'b0;
    send(8'h5A, 8, 1'b0, 1'b0, 0, 1'b1);
    bus_read(1'b0, v); check("R10 loopback char", v, 16'h005A);
    rx_serial = 1'b1;
    @(negedge clk);
    loop_en = 1'b0;
    repeat (BIT) @(negedge clk);
    bus_read(1'b0, v); check("R10 no frame from line", v, 16'h005A);

    running = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule